// File: doc/BRIEF.md
# Banked Interrupt Controller

This block collects a parameterised set of interrupt sources (64 by default) into two banks of 32 and turns them into two request lines for a processor: a normal request and a fast request. A fixed per-source map, chosen at build time, makes each source either level-sensitive or edge-sensitive. Edge-sensitive sources are caught by a rising-edge detector and held in a latch until software clears it. Level-sensitive sources are used as they stand, and a few of them can have their active level inverted. Software can also raise any source itself through a soft-trigger bit.

A source is pending when its latch is set (edge sources), its polarity-corrected input is active (level sources), or its soft-trigger bit is set. Each pending source passes through its enable bit. A route bit then sends it to the normal or the fast output. Software reaches everything through a single-cycle register port. Each per-source register has a copy for each bank, and the second bank's copy sits 4 bytes above the first. Enables and soft triggers have separate write-one-to-set and write-one-to-clear addresses.

The register byte addresses for bank 0 are listed below; add 4 for bank 1.

- 0x00: normal-route status, read only.
- 0x08: fast-route status, read only.
- 0x10: raw pending, read only.
- 0x18: route select, read/write.
- 0x20: sense, read only.
- 0x28: enable set; reads back the enables.
- 0x30: enable clear.
- 0x38: soft-trigger set; reads back the soft triggers.
- 0x40: soft-trigger clear.
- 0x48: edge-latch clear.
- 0x50: polarity, read/write.

The clear-only addresses read as 0.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset, enables, soft triggers, route bits, polarity bits and edge latches are all 0. Both request outputs are low.
- R2: Writing the enable-set address (0x28) sets the enable bits written as 1. Writing the enable-clear address (0x30) clears the enable bits written as 1. Bits written as 0 leave enables unchanged in both cases, and enables change only on these writes. Reading 0x28 returns the enables.
- R3: Writing the soft-set address (0x38) sets soft-trigger bits written as 1, and writing the soft-clear address (0x40) clears them. A set soft bit makes its source pending.
- R4: A route bit (0x18) of 0 sends an enabled pending source to irq_out and the normal status; a route bit of 1 sends it to fiq_out and the fast status. The two statuses never share a set bit.
- R5: The sense address (0x20) reads 1 for level-sensitive sources and 0 for edge-sensitive ones, as given by LEVEL_MAP, and writes to it change nothing.
- R6: A rising input on an edge source sets its latch at the next clock edge. The latch stays set, whatever the input does, until a 1 is written to that bit of the edge-clear address (0x48). A new edge in the same cycle as the clear leaves the latch set.
- R7: Writes to the edge-clear address have no effect on level-sensitive sources.
- R8: The normal status (0x00) reads enabled, pending sources routed normal, and the fast status (0x08) reads those routed fast; each reads 0 when none are pending. The raw address (0x10) reads every pending source regardless of enable.
- R9: irq_out is the OR of all normal status bits over both banks, and fiq_out is the OR of all fast status bits.
- R10: A polarity bit of 1 makes its level source active low. Only the sources in POL_MAP (bank 0 bits 0 to 3 by default) have a polarity bit; other polarity bits read 0 and ignore writes.
- R11: Each bank-1 register sits at its bank-0 address plus 4 and acts only on sources 32 to 63.
- R12: Read data appears on bus_rdata in the cycle after the read and holds until the next read. Addresses with bits [1:0] not zero, or above the polarity register, read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | 64 | Interrupt source inputs |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_out | output | 1 | Normal interrupt request |
| fiq_out | output | 1 | Fast interrupt request |

## Verification
The assertions take the source inputs and bus signals as stable at each clock edge, and assume the bus issues at most one access per cycle. Both hold because the bench drives every input on the falling clock edge. The latch-hold check assumes an edge input is not sampled as rising unless it was low in the prior cycle. The stimulus keeps to this by raising edge sources only from a low level held for at least one cycle. The one deliberate edge-and-clear collision is also staged from that low level.

// File: rtl/bic_pkg.sv
package bic_pkg;

    localparam int BANK_W     = 32;
    localparam int BANK_SEL_W = 1;
    localparam int NUM_BANKS  = 2 ** BANK_SEL_W;
    localparam int SRC_N      = NUM_BANKS * BANK_W;
    localparam int SEL_W      = 5;
    localparam int ADDR_W     = SEL_W + BANK_SEL_W + 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_NRM_STAT = 5'd0,
        SEL_FST_STAT = 5'd1,
        SEL_RAW      = 5'd2,
        SEL_ROUTE    = 5'd3,
        SEL_SENSE    = 5'd4,
        SEL_EN_SET   = 5'd5,
        SEL_EN_CLR   = 5'd6,
        SEL_SOFT_SET = 5'd7,
        SEL_SOFT_CLR = 5'd8,
        SEL_EDGE_CLR = 5'd9,
        SEL_POL      = 5'd10
    } reg_sel_e;

    typedef logic [NUM_BANKS-1:0][BANK_W-1:0] bank_vec_t;

endpackage

// File: rtl/bic_bank.sv
module bic_bank
    import bic_pkg::*;
#(
    parameter logic [BANK_W-1:0] LEVEL_MASK = '0,
    parameter logic [BANK_W-1:0] POL_MASK   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] src,
    input  logic              we_en_set,
    input  logic              we_en_clr,
    input  logic              we_soft_set,
    input  logic              we_soft_clr,
    input  logic              we_route,
    input  logic              we_edge_clr,
    input  logic              we_pol,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] en_q,
    output logic [BANK_W-1:0] soft_q,
    output logic [BANK_W-1:0] route_q,
    output logic [BANK_W-1:0] pol_q,
    output logic [BANK_W-1:0] pending,
    output logic [BANK_W-1:0] nrm_stat,
    output logic [BANK_W-1:0] fst_stat
);

    localparam logic [BANK_W-1:0] EDGE_MASK = ~LEVEL_MASK;

    logic [BANK_W-1:0] prev_q;
    logic [BANK_W-1:0] latch_q;
    logic [BANK_W-1:0] rise;
    logic [BANK_W-1:0] edge_clr;
    logic [BANK_W-1:0] latch_d;
    logic [BANK_W-1:0] active;

    always_comb begin
        rise     = src & ~prev_q;
        edge_clr = we_edge_clr ? wdata : '0;
        latch_d  = ((latch_q & ~edge_clr) | rise) & EDGE_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= '0;
            latch_q <= '0;
        end else begin
            prev_q  <= src;
            latch_q <= latch_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= '0;
            soft_q  <= '0;
            route_q <= '0;
            pol_q   <= '0;
        end else begin
            if (we_en_set)   en_q    <= en_q | wdata;
            if (we_en_clr)   en_q    <= en_q & ~wdata;
            if (we_soft_set) soft_q  <= soft_q | wdata;
            if (we_soft_clr) soft_q  <= soft_q & ~wdata;
            if (we_route)    route_q <= wdata;
            if (we_pol)      pol_q   <= wdata & POL_MASK;
        end
    end

    always_comb begin
        pending  = (LEVEL_MASK & (src ^ pol_q)) | latch_q | soft_q;
        active   = pending & en_q;
        nrm_stat = active & ~route_q;
        fst_stat = active & route_q;
    end

    // R6
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((latch_q & $past(latch_q & ~edge_clr)) == $past(latch_q & ~edge_clr)));

    // R2
    en_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_en_set || we_en_clr) |=> $stable(en_q));

    // R4
    route_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nrm_stat & fst_stat) == '0);

    // R10
    pol_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pol_q & ~POL_MASK) == '0);

endmodule

// File: rtl/bic_regif.sv
module bic_regif
    import bic_pkg::*;
#(
    parameter logic [SRC_N-1:0] LEVEL_MAP = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_valid,
    input  logic                  bus_write,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  bank_vec_t             rb_nrm,
    input  bank_vec_t             rb_fst,
    input  bank_vec_t             rb_raw,
    input  bank_vec_t             rb_route,
    input  bank_vec_t             rb_en,
    input  bank_vec_t             rb_soft,
    input  bank_vec_t             rb_pol,
    output logic                  wr_go,
    output reg_sel_e              wr_sel,
    output logic [BANK_SEL_W-1:0] wr_bank,
    output logic [BANK_W-1:0]     bus_rdata
);

    logic                  aligned;
    logic                  rd_go;
    logic [BANK_SEL_W-1:0] bank;
    reg_sel_e              sel;
    logic [BANK_W-1:0]     rd_val;

    always_comb begin
        aligned = (bus_addr[1:0] == 2'b00);
        bank    = bus_addr[BANK_SEL_W+1:2];
        sel     = reg_sel_e'(bus_addr[ADDR_W-1:BANK_SEL_W+2]);
        wr_go   = bus_valid && bus_write && aligned;
        rd_go   = bus_valid && !bus_write;
        wr_sel  = sel;
        wr_bank = bank;
    end

    always_comb begin
        rd_val = '0;
        if (aligned) begin
            case (sel)
                SEL_NRM_STAT: rd_val = rb_nrm[bank];
                SEL_FST_STAT: rd_val = rb_fst[bank];
                SEL_RAW:      rd_val = rb_raw[bank];
                SEL_ROUTE:    rd_val = rb_route[bank];
                SEL_SENSE:    rd_val = LEVEL_MAP[bank*BANK_W +: BANK_W];
                SEL_EN_SET:   rd_val = rb_en[bank];
                SEL_SOFT_SET: rd_val = rb_soft[bank];
                SEL_POL:      rd_val = rb_pol[bank];
                default:      rd_val = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (rd_go) begin
            bus_rdata <= rd_val;
        end
    end

    // R12
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> $stable(bus_rdata));

endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
    import bic_pkg::*;
#(
    parameter logic [SRC_N-1:0] LEVEL_MAP = 64'h0000_00F0_0000_F00F,
    parameter logic [SRC_N-1:0] POL_MAP   = 64'h0000_0000_0000_000F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_N-1:0]  src_in,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BANK_W-1:0] bus_wdata,
    output logic [BANK_W-1:0] bus_rdata,
    output logic              irq_out,
    output logic              fiq_out
);

    bank_vec_t             nrm_v, fst_v, raw_v, route_v, en_v, soft_v, pol_v;
    logic                  wr_go;
    reg_sel_e              wr_sel;
    logic [BANK_SEL_W-1:0] wr_bank;

    bic_regif #(.LEVEL_MAP(LEVEL_MAP)) u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .rb_nrm    (nrm_v),
        .rb_fst    (fst_v),
        .rb_raw    (raw_v),
        .rb_route  (route_v),
        .rb_en     (en_v),
        .rb_soft   (soft_v),
        .rb_pol    (pol_v),
        .wr_go     (wr_go),
        .wr_sel    (wr_sel),
        .wr_bank   (wr_bank),
        .bus_rdata (bus_rdata)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = wr_go && (wr_bank == BANK_SEL_W'(b));

        bic_bank #(
            .LEVEL_MASK (LEVEL_MAP[b*BANK_W +: BANK_W]),
            .POL_MASK   (POL_MAP[b*BANK_W +: BANK_W])
        ) u_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .src         (src_in[b*BANK_W +: BANK_W]),
            .we_en_set   (hit && wr_sel == SEL_EN_SET),
            .we_en_clr   (hit && wr_sel == SEL_EN_CLR),
            .we_soft_set (hit && wr_sel == SEL_SOFT_SET),
            .we_soft_clr (hit && wr_sel == SEL_SOFT_CLR),
            .we_route    (hit && wr_sel == SEL_ROUTE),
            .we_edge_clr (hit && wr_sel == SEL_EDGE_CLR),
            .we_pol      (hit && wr_sel == SEL_POL),
            .wdata       (bus_wdata),
            .en_q        (en_v[b]),
            .soft_q      (soft_v[b]),
            .route_q     (route_v[b]),
            .pol_q       (pol_v[b]),
            .pending     (raw_v[b]),
            .nrm_stat    (nrm_v[b]),
            .fst_stat    (fst_v[b])
        );
    end

    always_comb begin
        irq_out = |nrm_v;
        fiq_out = |fst_v;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!irq_out && !fiq_out) || !rst_n);

endmodule

// File: tb/banked_irq_ctrl_tb.sv
module banked_irq_ctrl_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src_in = '0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;
    logic        fiq_out;

    int total = 0;
    int bad = 0;
    logic rd_seen = 1'b0;
    logic [31:0] exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    banked_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .src_in(src_in),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out), .fiq_out(fiq_out)
    );

    always @(posedge clk) rd_seen <= bus_valid && !bus_write;

    // monitor: compares each returned read with the scoreboard head
    always @(negedge clk) begin
        if (rd_seen) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            total++;
            if (bus_rdata !== e) begin
                bad++;
                $display("FAIL %s: rdata got %08h exp %08h", t, bus_rdata, e);
            end
        end
    end

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        tick();
        bus_valid = 1'b0;
        tick();
    endtask

    task automatic pin(input logic got, input logic e, input string t);
        total++;
        if (got !== e) begin
            bad++;
            $display("FAIL %s: got %0b exp %0b", t, got, e);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        bad++; total++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick();
        // R1 reset state
        pin(irq_out, 1'b0, "R1 irq_out");
        pin(fiq_out, 1'b0, "R1 fiq_out");
        rd(8'h28, 32'h0, "R1 enable");
        rd(8'h38, 32'h0, "R1 soft");
        rd(8'h18, 32'h0, "R1 route");
        rd(8'h50, 32'h0, "R1 polarity");
        rd(8'h10, 32'h0, "R1 raw");
        rd(8'h14, 32'h0, "R1 raw bank1");
        // R2 enables
        wr(8'h28, 32'h0000_00F0);
        wr(8'h28, 32'h0000_0300);
        rd(8'h28, 32'h0000_03F0, "R2 set accumulates");
        wr(8'h30, 32'h0000_0010);
        rd(8'h28, 32'h0000_03E0, "R2 clear one bit");
        // R11 bank1
        wr(8'h2C, 32'h8000_0001);
        rd(8'h2C, 32'h8000_0001, "R11 bank1 enable");
        rd(8'h28, 32'h0000_03E0, "R11 bank0 untouched");
        // R3 soft, R4 route, R8 status
        wr(8'h38, 32'h0000_0020);
        pin(irq_out, 1'b1, "R3 soft raises irq");
        rd(8'h00, 32'h0000_0020, "R8 normal status");
        rd(8'h10, 32'h0000_0020, "R8 raw");
        wr(8'h18, 32'h0000_0020);
        pin(fiq_out, 1'b1, "R4 routed fast");
        pin(irq_out, 1'b0, "R9 irq low when routed fast");
        rd(8'h08, 32'h0000_0020, "R4 fast status");
        rd(8'h00, 32'h0, "R4 normal status empty");
        wr(8'h40, 32'h0000_0020);
        rd(8'h38, 32'h0, "R3 soft cleared");
        pin(fiq_out, 1'b0, "R3 fiq low after clear");
        wr(8'h18, 32'h0);
        // R6 edge source 8
        src_in[8] = 1'b1;
        tick();
        pin(irq_out, 1'b1, "R6 edge latched");
        src_in[8] = 1'b0;
        tick();
        rd(8'h10, 32'h0000_0100, "R6 latch holds");
        wr(8'h48, 32'h0000_0100);
        rd(8'h10, 32'h0, "R6 latch cleared");
        pin(irq_out, 1'b0, "R6 irq low");
        src_in[8] = 1'b1;
        wr(8'h48, 32'h0000_0100);
        rd(8'h10, 32'h0000_0100, "R6 edge wins over clear");
        wr(8'h48, 32'h0000_0100);
        rd(8'h10, 32'h0, "R6 no re-latch while high");
        src_in[8] = 1'b0;
        // R11 bank1 edge source 63
        src_in[63] = 1'b1;
        tick();
        rd(8'h04, 32'h8000_0000, "R11 bank1 edge status");
        pin(irq_out, 1'b1, "R9 irq from bank1");
        wr(8'h4C, 32'h8000_0000);
        rd(8'h04, 32'h0, "R11 bank1 edge cleared");
        src_in[63] = 1'b0;
        // R7 level source 12
        wr(8'h28, 32'h0000_1000);
        src_in[12] = 1'b1;
        tick();
        pin(irq_out, 1'b1, "R7 level active");
        wr(8'h48, 32'h0000_1000);
        rd(8'h10, 32'h0000_1000, "R7 edge clear ignored");
        src_in[12] = 1'b0;
        tick();
        rd(8'h10, 32'h0, "R7 level released");
        pin(irq_out, 1'b0, "R7 irq low");
        // R10 polarity
        wr(8'h50, 32'hFFFF_FFFF);
        rd(8'h50, 32'h0000_000F, "R10 only programmable bits");
        rd(8'h10, 32'h0000_000F, "R10 active low pending");
        pin(irq_out, 1'b0, "R10 not enabled");
        wr(8'h54, 32'hFFFF_FFFF);
        rd(8'h54, 32'h0, "R10 bank1 no polarity");
        wr(8'h50, 32'h0);
        rd(8'h10, 32'h0, "R10 restored");
        // R11 bank1 level source 36
        wr(8'h2C, 32'h0000_0010);
        rd(8'h2C, 32'h8000_0011, "R2 bank1 set");
        src_in[36] = 1'b1;
        tick();
        rd(8'h04, 32'h0000_0010, "R11 bank1 level status");
        wr(8'h1C, 32'h0000_0010);
        pin(fiq_out, 1'b1, "R4 bank1 fast");
        rd(8'h0C, 32'h0000_0010, "R11 bank1 fast status");
        src_in[36] = 1'b0;
        tick();
        pin(fiq_out, 1'b0, "R9 fiq low");
        // R5 sense
        wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h20, 32'h0000_F00F, "R5 sense bank0");
        rd(8'h24, 32'h0000_00F0, "R5 sense bank1");
        // R12 unmapped and misaligned
        wr(8'h60, 32'hFFFF_FFFF);
        rd(8'h60, 32'h0, "R12 unmapped");
        wr(8'h29, 32'hFFFF_FFFF);
        rd(8'h29, 32'h0, "R12 misaligned read");
        rd(8'h28, 32'h0000_13E0, "R12 misaligned write ignored");
        tick(2);
        if (exp_q.size() != 0) begin
            bad++; total++;
            $display("FAIL R12: got %0d pending reads exp 0", exp_q.size());
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule